// File: doc/BRIEF.md
# Adaptive Delta Modulation Bitstream Decoder

The block turns a one-bit adaptive delta modulation stream back into 16-bit linear PCM. A bit is presented with a strobe. For each bit, the block updates a companded step size and then moves the estimate up or down by that step. The new estimate appears at the PCM output one cycle later.

A shift register of recent bits feeds a run detector. When the last N bits agree, the step grows by a fixed increment. Otherwise the step decays by a programmable shift. The step always stays inside programmable bounds. The estimate is normally a single leaky integrator. When second-order mode is on, a second leaky integrator sits between the step and the principal integrator. An external linear PCM sample can be added to the output, so that the output stands for both streams together. All leak factors are right shifts set from configuration inputs. That makes the block fit CVSD-style schemes and their relatives.

Top module: `adm_decoder`

## Requirements
- R1: Synchronous reset clears pcm_out and pcm_valid to 0. It also zeroes the estimate, the second integrator, the step register, the bit history and the count of received bits.
- R2: pcm_valid is 1 in the cycle after each cycle with bit_valid=1 and 0 otherwise. pcm_out changes only in the cycle after a strobed bit.
- R3: After each bit, the step equals clamp(candidate, cfg_step_min, cfg_step_max). Values below the minimum are raised to it and values above the maximum are lowered to it, given min <= max.
- R4: A run exists when at least D bits have arrived since reset and the newest D bits, including the current one, are all equal. D is the effective depth. On a run the candidate step is step + STEP_INC (default 32).
- R5: Without a run the candidate step is step - (step >>> cfg_decay_shift). A shift of 0 means no decay.
- R6: In first-order mode the estimate becomes est - (est >>> cfg_est_shift) + d. Here d = +step for adm_bit=1 and -step for adm_bit=0, using the step already updated for this bit. A shift of 0 means no leak.
- R7: With cfg_second_en=1 the second integrator becomes sec - (sec >>> cfg_sec_shift) + d, and the estimate becomes est - (est >>> cfg_est_shift) + sec_new. With cfg_second_en=0 the second integrator is held at 0.
- R8: The effective depth is cfg_depth clamped to 1..MAX_DEPTH (default 8). A value of 0 acts as 1, and values above MAX_DEPTH act as MAX_DEPTH.
- R9: Every 16-bit signed sum saturates at 32767 and -32768 and never wraps. This covers the step, both integrators and the output sum.
- R10: With sum_en=1, pcm_out is the saturated sum of the new estimate and pcm_in.
- R11: With sum_en=0, pcm_in is ignored and pcm_out equals the new estimate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_valid | input | 1 | Strobe marking a new ADM bit |
| adm_bit | input | 1 | ADM bit, 1 = up, 0 = down |
| cfg_depth | input | 4 | Run-detection depth |
| cfg_est_shift | input | 4 | Principal integrator leak shift |
| cfg_sec_shift | input | 4 | Second integrator leak shift |
| cfg_decay_shift | input | 4 | Step decay shift |
| cfg_step_min | input | 16 | Lower step bound (signed) |
| cfg_step_max | input | 16 | Upper step bound (signed) |
| cfg_second_en | input | 1 | Enable second-order mode |
| sum_en | input | 1 | Add pcm_in into the output |
| pcm_in | input | 16 | Linear PCM sample to sum (signed) |
| pcm_out | output | 16 | Reconstructed PCM (signed) |
| pcm_valid | output | 1 | Marks a new pcm_out value |

## Verification
The bench sweeps ten configurations. They cover a depth of one, depths of 0 and 15 that must be clamped, narrow step bounds, zero shifts, second-order mode, long saturating runs, and summing with the sum turned on and off. Every output sample is compared with an arithmetic model.

Each mistake shows up in its own way:
- A design that ignores the fill count would report runs before enough bits arrive, and its steps would be too large early on.
- A design that uses the old step instead of the new one would be off by one adaptation on every sample.
- A wrapping adder would flip the sign at full scale.
- A design that leaks pcm_in while summing is off would offset the output.

Idle cycles placed between bits show whether pcm_out holds its value and whether pcm_valid drops.

// File: rtl/adm_pkg.sv
package adm_pkg;
  localparam int ACC_W   = 16;
  localparam int SHIFT_W = 4;

  typedef logic signed [ACC_W-1:0] acc_t;
  typedef logic [SHIFT_W-1:0]      shamt_t;

  localparam acc_t ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam acc_t ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};

  // saturating add: overflow shows as disagreement of the two top bits
  function automatic acc_t sat_add(acc_t a, acc_t b);
    logic [ACC_W:0] s;
    s = {a[ACC_W-1], a} + {b[ACC_W-1], b};
    if (s[ACC_W] != s[ACC_W-1]) return s[ACC_W] ? ACC_MIN : ACC_MAX;
    return acc_t'(s[ACC_W-1:0]);
  endfunction

  function automatic acc_t sat_sub(acc_t a, acc_t b);
    logic [ACC_W:0] s;
    s = {a[ACC_W-1], a} - {b[ACC_W-1], b};
    if (s[ACC_W] != s[ACC_W-1]) return s[ACC_W] ? ACC_MIN : ACC_MAX;
    return acc_t'(s[ACC_W-1:0]);
  endfunction

  // leak term; a shift of zero disables the leak
  function automatic acc_t leak(acc_t v, shamt_t k);
    if (k == '0) return '0;
    return v >>> k;
  endfunction

  function automatic acc_t clamp(acc_t v, acc_t lo, acc_t hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction
endpackage

// File: rtl/adm_run_detect.sv
module adm_run_detect #(
  parameter int MAX_DEPTH = 8,
  parameter int DEPTH_W   = $clog2(MAX_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bit_valid,
  input  logic               adm_bit,
  input  logic [DEPTH_W-1:0] cfg_depth,
  output logic               run_hit
);
  localparam logic [DEPTH_W-1:0] DMAX = DEPTH_W'(MAX_DEPTH);

  logic [MAX_DEPTH-1:0] hist_q, hist_nx, agree, need;
  logic [DEPTH_W-1:0]   fill_q, fill_nx, depth_eff;

  assign hist_nx = {hist_q[MAX_DEPTH-2:0], adm_bit};
  assign fill_nx = (fill_q == DMAX) ? DMAX : fill_q + 1'b1;

  always_comb begin
    if (cfg_depth == '0)       depth_eff = DEPTH_W'(1);
    else if (cfg_depth > DMAX) depth_eff = DMAX;
    else                       depth_eff = cfg_depth;
  end

  for (genvar i = 0; i < MAX_DEPTH; i++) begin : g_tap
    assign agree[i] = (hist_nx[i] == adm_bit);
    assign need[i]  = (DEPTH_W'(i) < depth_eff);
  end

  assign run_hit = (fill_nx >= depth_eff) && (&(agree | ~need));

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q <= '0;
      fill_q <= '0;
    end else if (bit_valid) begin
      hist_q <= hist_nx;
      fill_q <= fill_nx;
    end
  end

  // R8: depth 0 acts as depth 1, so every bit is a run
  p_zero_depth_r8: assert property (@(posedge clk) disable iff (rst)
    (bit_valid && cfg_depth == '0) |-> run_hit);
  // R4: on the first bit after reset only depth one can report a run
  p_fill_gate_r4: assert property (@(posedge clk) disable iff (rst)
    (bit_valid && fill_q == '0 && cfg_depth > DEPTH_W'(1)) |-> !run_hit);
endmodule

// File: rtl/adm_step_ctrl.sv
module adm_step_ctrl
  import adm_pkg::*;
#(
  parameter int STEP_INC = 32
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   bit_valid,
  input  logic   run_hit,
  input  shamt_t cfg_decay_shift,
  input  acc_t   cfg_step_min,
  input  acc_t   cfg_step_max,
  output acc_t   step_nx,
  output acc_t   step_q
);
  localparam acc_t INC = acc_t'(STEP_INC);

  acc_t step_raw;

  assign step_raw = run_hit ? sat_add(step_q, INC)
                            : sat_sub(step_q, leak(step_q, cfg_decay_shift));
  assign step_nx  = clamp(step_raw, cfg_step_min, cfg_step_max);

  always_ff @(posedge clk) begin
    if (rst)            step_q <= '0;
    else if (bit_valid) step_q <= step_nx;
  end

  p_step_range_r3: assert property (@(posedge clk) disable iff (rst)
    (bit_valid && cfg_step_min <= cfg_step_max) |=>
      (step_q >= $past(cfg_step_min) && step_q <= $past(cfg_step_max)));
  p_run_grows_r4: assert property (@(posedge clk) disable iff (rst)
    (bit_valid && run_hit && step_q >= cfg_step_min && step_q <= cfg_step_max) |=>
      (step_q > $past(step_q) || step_q == $past(cfg_step_max)));
  p_decay_r5: assert property (@(posedge clk) disable iff (rst)
    (bit_valid && !run_hit && step_q >= cfg_step_min && step_q <= cfg_step_max
     && step_q >= 0) |=> step_q <= $past(step_q));
endmodule

// File: rtl/adm_integrators.sv
module adm_integrators
  import adm_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   bit_valid,
  input  logic   adm_bit,
  input  acc_t   step_in,
  input  logic   cfg_second_en,
  input  shamt_t cfg_est_shift,
  input  shamt_t cfg_sec_shift,
  output acc_t   est_nx,
  output acc_t   est_q
);
  acc_t sec_q, sec_nx, delta, drive;

  assign delta  = adm_bit ? step_in : acc_t'(-step_in);
  assign sec_nx = cfg_second_en
                  ? sat_add(sat_sub(sec_q, leak(sec_q, cfg_sec_shift)), delta)
                  : '0;
  assign drive  = cfg_second_en ? sec_nx : delta;
  assign est_nx = sat_add(sat_sub(est_q, leak(est_q, cfg_est_shift)), drive);

  always_ff @(posedge clk) begin
    if (rst) begin
      sec_q <= '0;
      est_q <= '0;
    end else if (bit_valid) begin
      sec_q <= sec_nx;
      est_q <= est_nx;
    end
  end

  p_sec_idle_r7: assert property (@(posedge clk) disable iff (rst)
    (bit_valid && !cfg_second_en) |=> sec_q == '0);
  p_rise_r6: assert property (@(posedge clk) disable iff (rst)
    (bit_valid && adm_bit && !cfg_second_en && cfg_est_shift == '0 && step_in >= 0)
      |=> est_q >= $past(est_q));
  p_no_wrap_r9: assert property (@(posedge clk) disable iff (rst)
    (bit_valid && adm_bit && !cfg_second_en && cfg_est_shift == '0
     && step_in >= 0 && est_q == ACC_MAX) |=> est_q == ACC_MAX);
endmodule

// File: rtl/adm_decoder.sv
module adm_decoder
  import adm_pkg::*;
#(
  parameter int MAX_DEPTH = 8,
  parameter int STEP_INC  = 32,
  parameter int DEPTH_W   = $clog2(MAX_DEPTH + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    bit_valid,
  input  logic                    adm_bit,
  input  logic [DEPTH_W-1:0]      cfg_depth,
  input  logic [SHIFT_W-1:0]      cfg_est_shift,
  input  logic [SHIFT_W-1:0]      cfg_sec_shift,
  input  logic [SHIFT_W-1:0]      cfg_decay_shift,
  input  logic signed [ACC_W-1:0] cfg_step_min,
  input  logic signed [ACC_W-1:0] cfg_step_max,
  input  logic                    cfg_second_en,
  input  logic                    sum_en,
  input  logic signed [ACC_W-1:0] pcm_in,
  output logic signed [ACC_W-1:0] pcm_out,
  output logic                    pcm_valid
);
  logic run_hit;
  acc_t step_nx, step_q, est_nx, est_q, addend;

  adm_run_detect #(.MAX_DEPTH(MAX_DEPTH), .DEPTH_W(DEPTH_W)) u_run (
    .clk(clk), .rst(rst), .bit_valid(bit_valid), .adm_bit(adm_bit),
    .cfg_depth(cfg_depth), .run_hit(run_hit)
  );

  adm_step_ctrl #(.STEP_INC(STEP_INC)) u_step (
    .clk(clk), .rst(rst), .bit_valid(bit_valid), .run_hit(run_hit),
    .cfg_decay_shift(cfg_decay_shift), .cfg_step_min(cfg_step_min),
    .cfg_step_max(cfg_step_max), .step_nx(step_nx), .step_q(step_q)
  );

  adm_integrators u_int (
    .clk(clk), .rst(rst), .bit_valid(bit_valid), .adm_bit(adm_bit),
    .step_in(step_nx), .cfg_second_en(cfg_second_en),
    .cfg_est_shift(cfg_est_shift), .cfg_sec_shift(cfg_sec_shift),
    .est_nx(est_nx), .est_q(est_q)
  );

  assign addend = sum_en ? pcm_in : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      pcm_out   <= '0;
      pcm_valid <= 1'b0;
    end else begin
      pcm_valid <= bit_valid;
      if (bit_valid) pcm_out <= sat_add(est_nx, addend);
    end
  end

  p_valid_r2: assert property (@(posedge clk) disable iff (rst)
    bit_valid |=> pcm_valid);
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !bit_valid |=> (!pcm_valid && $stable(pcm_out)));
  p_sum_off_r11: assert property (@(posedge clk) disable iff (rst)
    (bit_valid && !sum_en) |=> pcm_out == est_q);
endmodule

// File: tb/adm_decoder_tb.sv
module adm_decoder_tb;
  localparam int CLK_P = 10;
  localparam int MAXD  = 8;
  localparam int INC   = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_valid = 1'b0, adm_bit = 1'b0;
  logic [3:0] cfg_depth = 4'd1, cfg_est_shift = '0, cfg_sec_shift = '0, cfg_decay_shift = '0;
  logic signed [15:0] cfg_step_min = 16'sd1, cfg_step_max = 16'sd100;
  logic cfg_second_en = 1'b0, sum_en = 1'b0;
  logic signed [15:0] pcm_in = '0;
  logic signed [15:0] pcm_out;
  logic pcm_valid;

  int total = 0, bad = 0;
  bit done = 0;
  logic [15:0] lfsr = 16'hACE1;
  int m_est, m_sec, m_step, m_hist, m_fill, m_out;

  always #(CLK_P/2) clk = ~clk;

  adm_decoder u_dut (
    .clk(clk), .rst(rst), .bit_valid(bit_valid), .adm_bit(adm_bit),
    .cfg_depth(cfg_depth), .cfg_est_shift(cfg_est_shift),
    .cfg_sec_shift(cfg_sec_shift), .cfg_decay_shift(cfg_decay_shift),
    .cfg_step_min(cfg_step_min), .cfg_step_max(cfg_step_max),
    .cfg_second_en(cfg_second_en), .sum_en(sum_en), .pcm_in(pcm_in),
    .pcm_out(pcm_out), .pcm_valid(pcm_valid)
  );

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic int sat16(int v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic int lk(int v, int k);
    return (k == 0) ? 0 : (v >>> k);
  endfunction

  // reference arithmetic for one bit, written from the requirements
  task automatic model_bit(int b, int pv);
    int n, mask, d, tail;
    bit run;
    n = int'(cfg_depth);
    if (n < 1) n = 1;
    if (n > MAXD) n = MAXD;
    m_hist = ((m_hist << 1) | b) & 32'hFF;
    if (m_fill < MAXD) m_fill++;
    mask = (1 << n) - 1;
    tail = m_hist & mask;
    run = (m_fill >= n) && (tail == 0 || tail == mask);
    if (run) m_step = m_step + INC;
    else     m_step = m_step - lk(m_step, int'(cfg_decay_shift));
    m_step = sat16(m_step);
    if (m_step < int'(cfg_step_min)) m_step = int'(cfg_step_min);
    if (m_step > int'(cfg_step_max)) m_step = int'(cfg_step_max);
    d = b ? m_step : -m_step;
    if (cfg_second_en) begin
      m_sec = sat16(m_sec - lk(m_sec, int'(cfg_sec_shift)) + d);
      m_est = sat16(m_est - lk(m_est, int'(cfg_est_shift)) + m_sec);
    end else begin
      m_sec = 0;
      m_est = sat16(m_est - lk(m_est, int'(cfg_est_shift)) + d);
    end
    m_out = sat16(m_est + (sum_en ? pv : 0));
  endtask

  task automatic do_bit(string tag, int b, int pv);
    bit_valid = 1'b1;
    adm_bit   = b[0];
    pcm_in    = 16'(pv);
    model_bit(b, pv);
    @(negedge clk);
    bit_valid = 1'b0;
    chk("R2", int'(pcm_valid), 1);
    chk(tag, int'(pcm_out), m_out);
  endtask

  task automatic do_idle();
    bit_valid = 1'b0;
    pcm_in = 16'sd12345;
    @(negedge clk);
    chk("R2", int'(pcm_valid), 0);
    chk("R2", int'(pcm_out), m_out);
  endtask

  task automatic run_cfg(string tag, int dep, int es, int ss, int ds, int mn, int mx,
                         bit sec, bit sm, int nbits, int burst);
    int pv;
    rst = 1'b1;
    bit_valid = 1'b0;
    cfg_depth = 4'(dep); cfg_est_shift = 4'(es); cfg_sec_shift = 4'(ss);
    cfg_decay_shift = 4'(ds); cfg_step_min = 16'(mn); cfg_step_max = 16'(mx);
    cfg_second_en = sec; sum_en = sm;
    repeat (2) @(negedge clk);
    chk("R1", int'(pcm_out), 0);
    chk("R1", int'(pcm_valid), 0);
    rst = 1'b0;
    m_est = 0; m_sec = 0; m_step = 0; m_hist = 0; m_fill = 0; m_out = 0;
    for (int i = 0; i < nbits; i++) begin
      int b;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      pv = int'($signed(lfsr));
      if (i % 5 == 0) pv = (lfsr[3]) ? 32767 : -32768;
      if (i < nbits - 2*burst)  b = int'(lfsr[0]);
      else if (i < nbits - burst) b = 1;
      else b = 0;
      do_bit(tag, b, pv);
      if (i % 11 == 10) do_idle();
    end
  endtask

  initial begin
    repeat (2) @(negedge clk);
    run_cfg("R6",  4, 4, 0, 3,   8,  1024, 1'b0, 1'b0, 240, 40);
    run_cfg("R3",  3, 3, 0, 2, 100,   300, 1'b0, 1'b0, 240, 40);
    run_cfg("R4",  1, 5, 0, 4,   4,  4000, 1'b0, 1'b0, 200, 40);
    run_cfg("R5",  6, 4, 0, 1,   1,  2000, 1'b0, 1'b0, 240, 40);
    run_cfg("R7",  3, 3, 2, 3,   8,   600, 1'b1, 1'b0, 240, 40);
    run_cfg("R8",  0, 4, 0, 2,   8,  1500, 1'b0, 1'b0, 160, 30);
    run_cfg("R8", 15, 4, 0, 2,   8,  1500, 1'b0, 1'b0, 200, 30);
    run_cfg("R9",  2, 0, 0, 0, 100,  8000, 1'b0, 1'b0, 340, 150);
    run_cfg("R10", 4, 3, 0, 3,  16,  3000, 1'b0, 1'b1, 240, 60);
    run_cfg("R11", 4, 3, 0, 3,  16,  3000, 1'b0, 1'b0, 200, 40);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule